// File: doc/BRIEF.md
# Backplane Slave Cycle Responder

This block is the slave end of an asynchronous parallel backplane. It watches the address, address-modifier and strobe lines and decides whether a cycle is meant for its address window. If it is, the block finishes the cycle with the four-edge handshake. It asserts an acknowledge once the data has been captured or presented, and releases the acknowledge only after the master lets go of both data strobes. Cycles that it does not support are ignored, and the acknowledge is never driven for them.

Two cycle types are accepted. The first is a single 32-bit read or write. The second is a 64-bit multiplexed block transfer, where the start address is sent once and then advanced locally after each beat. In that mode the address lines, the long-word line and the data lines together carry one 64-bit word per beat. Every backplane input passes through a two-flop synchroniser before the state machine uses it. The window is backed by a local store built as two 32-bit banks. A registered local port shows the offset, data and bank enables of each write, and a one-cycle board-select pulse marks every accepted cycle.

Top module: `vme_slave_responder`

## Requirements
- R1: While reset is held, and in the cycle after it, the acknowledge pull, both line-drive enables and board-select are all low.
- R2: A single write (modifier 0x09, long-word line low, address bit 1 low, upper address bits equal to `base_i`) stores the data-line word at the word offset given by address bits 7:2. The acknowledge is pulled, and the local port then shows that byte offset and word.
- R3: A single read with the same qualification returns the stored word on the data lines, with the data drive enable high only while the acknowledge is pulled.
- R4: Once pulled, the acknowledge stays pulled until both data strobes are high. It is released after that even though the address strobe was already withdrawn.
- R5: A cycle whose modifier is neither 0x09 nor 0x08 gets no acknowledge and leaves the store unchanged.
- R6: A cycle whose upper address bits differ from `base_i` gets no acknowledge and leaves the store unchanged.
- R7: A single cycle with the long-word line high (narrow width), or with address bit 1 high, is ignored.
- R8: In a block transfer (modifier 0x08) the first strobe handshake only acknowledges the address. Each later beat carries one 64-bit word: bits 63:33 on address lines 31:1, bit 32 on the long-word line level, bits 31:0 on the data lines. The low half is stored at the current offset and the high half at the current offset plus 4.
- R9: The block offset advances by 8 after each data beat and wraps within the 256-byte window.
- R10: A block read drives the address lines, the long-word line and the data lines with the same 64-bit layout as R8, while the acknowledge is pulled.
- R11: Board-select pulses for exactly one cycle per accepted cycle and never for an ignored one.
- R12: A block transfer whose start address is not 8-byte aligned (address bit 2 or 1 high) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 24 | Required value of address bits 31:8 |
| bus_am_i | input | 6 | Address-modifier lines |
| bus_a_i | input | 31 | Address lines 31:1 (data in block writes) |
| bus_lword_n_i | input | 1 | Long-word line, active low |
| bus_as_n_i | input | 1 | Address strobe, active low |
| bus_ds0_n_i | input | 1 | Data strobe 0, active low |
| bus_ds1_n_i | input | 1 | Data strobe 1, active low |
| bus_write_n_i | input | 1 | Write line, low means write |
| bus_d_i | input | 32 | Data lines in |
| bus_d_o | output | 32 | Data lines out |
| bus_d_oe | output | 1 | Drive enable for data lines |
| bus_a_o | output | 31 | Address lines out (block reads) |
| bus_lword_n_o | output | 1 | Long-word line out (block reads) |
| bus_a_oe | output | 1 | Drive enable for address and long-word lines |
| bus_dtack_pull | output | 1 | High pulls the acknowledge line low; low leaves it undriven |
| bsel_o | output | 1 | One-cycle board-select pulse |
| lcl_addr_o | output | 8 | Byte offset of the last local write |
| lcl_wdata_o | output | 64 | Data of the last local write (high, low bank) |
| lcl_we_o | output | 2 | Bank enables of the local write, one cycle |

## Verification
The hardest case to reach is a block transfer that crosses the top of the window, because the offset has to step through the wrap boundary in the middle of one transfer. The stimulus starts a three-beat block write 16 bytes below the top of the window and then reads each landed word back with single reads. Further block and single cycles are driven with a qualifier that is off by one field each time: the modifier, the base, the width, or the alignment. A per-clock monitor flags any acknowledge or line drive that the reference model did not expect.

// File: rtl/vsr_pkg.sv
`timescale 1ns/1ps
package vsr_pkg;
  localparam logic [5:0] AM_SGL = 6'h09;
  localparam logic [5:0] AM_BLK = 6'h08;
  typedef enum logic [1:0] {KIND_NONE, KIND_SGL, KIND_BLK} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_SKIP, S_WAIT, S_XFER, S_ACK, S_TAIL} state_e;
endpackage

// File: rtl/vsr_sync.sv
`timescale 1ns/1ps
module vsr_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/vsr_decode.sv
`timescale 1ns/1ps
module vsr_decode
  import vsr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int WIN = 8
) (
  input  logic [AW-1:1]     addr,
  input  logic              lword_n,
  input  logic [5:0]        am,
  input  logic [AW-WIN-1:0] base,
  output kind_e             kind
);
  logic hit;
  assign hit = (addr[AW-1:WIN] == base);

  always_comb begin
    kind = KIND_NONE;
    if (hit && !lword_n) begin
      if (am == AM_SGL && !addr[1])
        kind = KIND_SGL;
      else if (am == AM_BLK && addr[2:1] == 2'b00)
        kind = KIND_BLK;
    end
  end
endmodule

// File: rtl/vsr_bank.sv
`timescale 1ns/1ps
module vsr_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    q <= mem[idx];
  end
endmodule

// File: rtl/vsr_engine.sv
`timescale 1ns/1ps
module vsr_engine
  import vsr_pkg::*;
#(
  parameter int WIN = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           as_n,
  input  logic           ds0_n,
  input  logic           ds1_n,
  input  logic           write_n,
  input  kind_e          kind,
  input  logic [WIN-1:1] offs,
  output logic [WIN-1:0] ptr,
  output logic           blk,
  output logic           rd,
  output logic           xfer,
  output logic           ack,
  output logic           ack_done,
  output logic           bsel
);
  localparam logic [WIN-1:0] STEP = WIN'(8);

  state_e state;
  logic   addr_done;
  logic   beat_data;
  logic   ds_on, ds_off;

  assign ds_on    = !ds0_n && !ds1_n;
  assign ds_off   = ds0_n && ds1_n;
  assign xfer     = (state == S_XFER);
  assign ack_done = (state == S_ACK) && ds_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ptr       <= '0;
      blk       <= 1'b0;
      rd        <= 1'b0;
      ack       <= 1'b0;
      bsel      <= 1'b0;
      addr_done <= 1'b0;
      beat_data <= 1'b0;
    end else begin
      bsel <= 1'b0;
      case (state)
        S_IDLE: if (!as_n) begin
          if (kind != KIND_NONE) begin
            state     <= S_WAIT;
            blk       <= (kind == KIND_BLK);
            rd        <= write_n;
            ptr       <= {offs, 1'b0};
            addr_done <= 1'b0;
            bsel      <= 1'b1;
          end else begin
            state <= S_SKIP;
          end
        end
        S_SKIP: if (as_n) state <= S_IDLE;
        S_WAIT: begin
          if (as_n) state <= S_IDLE;
          else if (ds_on) begin
            if (blk && !addr_done) begin
              state     <= S_ACK;
              ack       <= 1'b1;
              beat_data <= 1'b0;
              addr_done <= 1'b1;
            end else begin
              state <= S_XFER;
            end
          end
        end
        S_XFER: begin
          state     <= S_ACK;
          ack       <= 1'b1;
          beat_data <= 1'b1;
        end
        S_ACK: if (ds_off) begin
          ack <= 1'b0;
          if (blk && beat_data) ptr <= ptr + STEP;
          state <= blk ? S_WAIT : S_TAIL;
        end
        S_TAIL: if (as_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  dtack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !(ds0_n && ds1_n)) |=> ack);

  // R9
  blk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACK && ds_off && blk && beat_data) |=> (ptr == $past(ptr) + STEP));

  // R11
  bsel_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bsel |=> !bsel);

  // R8
  addr_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_XFER) |-> (!blk || addr_done));
endmodule

// File: rtl/vme_slave_responder.sv
`timescale 1ns/1ps
module vme_slave_responder
  import vsr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int WIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-WIN-1:0] base_i,
  input  logic [5:0]        bus_am_i,
  input  logic [AW-1:1]     bus_a_i,
  input  logic              bus_lword_n_i,
  input  logic              bus_as_n_i,
  input  logic              bus_ds0_n_i,
  input  logic              bus_ds1_n_i,
  input  logic              bus_write_n_i,
  input  logic [AW-1:0]     bus_d_i,
  output logic [AW-1:0]     bus_d_o,
  output logic              bus_d_oe,
  output logic [AW-1:1]     bus_a_o,
  output logic              bus_lword_n_o,
  output logic              bus_a_oe,
  output logic              bus_dtack_pull,
  output logic              bsel_o,
  output logic [WIN-1:0]    lcl_addr_o,
  output logic [2*AW-1:0]   lcl_wdata_o,
  output logic [1:0]        lcl_we_o
);
  localparam int DW    = AW;
  localparam int DEPTH = 2 ** (WIN - 3);
  localparam int BUS_W = 6 + (AW - 1) + 1 + DW;

  logic [BUS_W-1:0] bus_s;
  logic [3:0]       stb_s;
  logic [5:0]       am_s;
  logic [AW-1:1]    a_s;
  logic             lw_s;
  logic [DW-1:0]    d_s;

  vsr_sync #(.W(BUS_W), .INIT('0)) u_sync_bus (
    .clk(clk), .rst(rst),
    .d({bus_am_i, bus_a_i, bus_lword_n_i, bus_d_i}), .q(bus_s));
  vsr_sync #(.W(4), .INIT(4'hF)) u_sync_stb (
    .clk(clk), .rst(rst),
    .d({bus_as_n_i, bus_ds0_n_i, bus_ds1_n_i, bus_write_n_i}), .q(stb_s));

  assign {am_s, a_s, lw_s, d_s} = bus_s;

  kind_e          kind;
  logic [WIN-1:0] ptr;
  logic           blk, rd, xfer, ack, ack_done;

  vsr_decode #(.AW(AW), .WIN(WIN)) u_decode (
    .addr(a_s), .lword_n(lw_s), .am(am_s), .base(base_i), .kind(kind));

  vsr_engine #(.WIN(WIN)) u_engine (
    .clk(clk), .rst(rst),
    .as_n(stb_s[3]), .ds0_n(stb_s[2]), .ds1_n(stb_s[1]), .write_n(stb_s[0]),
    .kind(kind), .offs(a_s[WIN-1:1]),
    .ptr(ptr), .blk(blk), .rd(rd), .xfer(xfer), .ack(ack),
    .ack_done(ack_done), .bsel(bsel_o));

  logic [1:0]    we_b;
  logic [DW-1:0] wd_b [2];
  logic [DW-1:0] q_b  [2];

  always_comb begin
    wd_b[0] = d_s;
    wd_b[1] = blk ? {a_s, lw_s} : d_s;
    we_b[0] = xfer && !rd && (blk || !ptr[2]);
    we_b[1] = xfer && !rd && (blk || ptr[2]);
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    vsr_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .we(we_b[b]), .idx(ptr[WIN-1:3]),
      .wdata(wd_b[b]), .q(q_b[b]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_d_oe      <= 1'b0;
      bus_a_oe      <= 1'b0;
      bus_d_o       <= '0;
      bus_a_o       <= '0;
      bus_lword_n_o <= 1'b1;
      lcl_we_o      <= '0;
      lcl_addr_o    <= '0;
      lcl_wdata_o   <= '0;
    end else begin
      if (xfer && rd) begin
        bus_d_oe                 <= 1'b1;
        bus_a_oe                 <= blk;
        bus_d_o                  <= (blk || !ptr[2]) ? q_b[0] : q_b[1];
        {bus_a_o, bus_lword_n_o} <= q_b[1];
      end else if (ack_done) begin
        bus_d_oe <= 1'b0;
        bus_a_oe <= 1'b0;
      end
      lcl_we_o <= we_b;
      if (|we_b) begin
        lcl_addr_o  <= ptr;
        lcl_wdata_o <= {wd_b[1], wd_b[0]};
      end
    end
  end

  assign bus_dtack_pull = ack;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bus_dtack_pull && !bus_d_oe && !bus_a_oe && !bsel_o));

  // R3
  drive_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bus_d_oe |-> bus_dtack_pull);

  // R10
  addr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    bus_a_oe |-> bus_d_oe);
endmodule

// File: tb/sim_vme_slave_responder.sv
`timescale 1ns/1ps
module sim_vme_slave_responder;
  localparam logic [23:0] BASE = 24'hA5C301;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [5:0]  am = '0;
  logic [31:1] a_i = '0;
  logic        lw_n = 1'b1, as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, wr_n = 1'b1;
  logic [31:0] d_i = '0;
  logic [31:0] d_o;
  logic        d_oe, a_oe, lw_o, dtack, bsel;
  logic [31:1] a_o;
  logic [7:0]  lcl_addr;
  logic [63:0] lcl_wdata;
  logic [1:0]  lcl_we;

  vme_slave_responder u0 (
    .clk(clk), .rst(rst), .base_i(BASE), .bus_am_i(am), .bus_a_i(a_i),
    .bus_lword_n_i(lw_n), .bus_as_n_i(as_n), .bus_ds0_n_i(ds0_n),
    .bus_ds1_n_i(ds1_n), .bus_write_n_i(wr_n), .bus_d_i(d_i),
    .bus_d_o(d_o), .bus_d_oe(d_oe), .bus_a_o(a_o), .bus_lword_n_o(lw_o),
    .bus_a_oe(a_oe), .bus_dtack_pull(dtack), .bsel_o(bsel),
    .lcl_addr_o(lcl_addr), .lcl_wdata_o(lcl_wdata), .lcl_we_o(lcl_we));

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_sel = 0, exp_rd = 0;
  int bsel_cnt = 0, accepted = 0;
  bit prev_bsel = 0;
  logic [31:0] ref_mem [int];
  logic [63:0] bdat [4];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison against the bench's expectation of the bus
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (dtack && !exp_sel) chk("R5/R6 unexpected acknowledge", 64'(dtack), 64'd0);
      if (d_oe && !exp_rd)   chk("R3 unexpected data drive", 64'(d_oe), 64'd0);
      if (bsel && prev_bsel) chk("R11 board-select longer than one cycle", 64'd2, 64'd1);
      if (bsel) bsel_cnt++;
      prev_bsel = bsel;
    end
  end

  task automatic wait_for(input bit lvl, output bit seen);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dtack == lvl) begin seen = 1; break; end
    end
  endtask

  task automatic sgl(input logic [5:0] m, input logic [31:0] addr, input bit lwn,
                     input bit wr, input logic [31:0] wd, input bit accept,
                     output logic [31:0] rdv, output bit acked);
    bit rel;
    @(negedge clk);
    am = m; a_i = addr[31:1]; lw_n = lwn; wr_n = !wr; d_i = wd;
    exp_sel = accept; exp_rd = accept && !wr;
    repeat (2) @(negedge clk);
    as_n = 1'b0;
    @(negedge clk);
    ds0_n = 1'b0; ds1_n = 1'b0;
    if (accept) wait_for(1'b1, acked);
    else begin repeat (20) @(negedge clk); acked = dtack; end
    rdv = d_o;
    as_n = 1'b1;
    repeat (6) @(negedge clk);
    if (accept) chk("R4 acknowledge held while strobes low", 64'(dtack), 64'd1);
    ds0_n = 1'b1; ds1_n = 1'b1;
    wait_for(1'b0, rel);
    if (accept) chk("R4 acknowledge released after strobes", 64'(rel), 64'd1);
    repeat (3) @(negedge clk);
    exp_sel = 0; exp_rd = 0;
    if (accept) accepted++;
  endtask

  task automatic blk(input logic [31:0] addr, input bit wr, input int n,
                     input bit accept, output bit ok);
    bit seen;
    ok = 1;
    @(negedge clk);
    am = 6'h08; a_i = addr[31:1]; lw_n = 1'b0; wr_n = !wr;
    exp_sel = accept; exp_rd = 0;
    repeat (2) @(negedge clk);
    as_n = 1'b0;
    @(negedge clk);
    ds0_n = 1'b0; ds1_n = 1'b0;
    if (!accept) begin
      repeat (20) @(negedge clk);
      ok = !dtack;
      ds0_n = 1'b1; ds1_n = 1'b1; as_n = 1'b1;
      repeat (3) @(negedge clk);
      exp_sel = 0;
      return;
    end
    wait_for(1'b1, seen); ok &= seen;
    ds0_n = 1'b1; ds1_n = 1'b1;
    wait_for(1'b0, seen); ok &= seen;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wr) begin {a_i, lw_n} = bdat[i][63:32]; d_i = bdat[i][31:0]; end
      exp_rd = !wr;
      repeat (2) @(negedge clk);
      ds0_n = 1'b0; ds1_n = 1'b0;
      wait_for(1'b1, seen); ok &= seen;
      if (!wr) bdat[i] = {a_o, lw_o, d_o};
      if (!wr) chk("R10 address lines driven in block read", 64'(a_oe), 64'd1);
      ds0_n = 1'b1; ds1_n = 1'b1;
      wait_for(1'b0, seen); ok &= seen;
      repeat (2) @(negedge clk);
      exp_rd = 0;
    end
    as_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_sel = 0;
    accepted++;
  endtask

  function automatic logic [31:0] adr(input logic [7:0] off);
    return {BASE, off};
  endfunction

  initial begin
    logic [31:0] rv;
    bit ok, ak;
    logic [7:0] off;
    repeat (4) @(negedge clk);
    chk("R1 acknowledge in reset", 64'(dtack), 64'd0);
    chk("R1 drives in reset", 64'({d_oe, a_oe, bsel}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 quiet after reset", 64'({dtack, d_oe, a_oe, bsel}), 64'd0);

    // single writes then reads
    sgl(6'h09, adr(8'h10), 0, 1, 32'hDEADBEEF, 1, rv, ak); ref_mem[4] = 32'hDEADBEEF;
    chk("R2 write acknowledged", 64'(ak), 64'd1);
    chk("R2 local offset", 64'(lcl_addr), 64'h10);
    chk("R2 local data", 64'(lcl_wdata[31:0]), 64'hDEADBEEF);
    sgl(6'h09, adr(8'h14), 0, 1, 32'h12345678, 1, rv, ak); ref_mem[5] = 32'h12345678;
    chk("R2 local offset upper bank", 64'(lcl_addr), 64'h14);
    sgl(6'h09, adr(8'h10), 0, 0, 32'h0, 1, rv, ak);
    chk("R3 read word 0x10", 64'(rv), 64'(ref_mem[4]));
    sgl(6'h09, adr(8'h14), 0, 0, 32'h0, 1, rv, ak);
    chk("R3 read word 0x14", 64'(rv), 64'(ref_mem[5]));

    // ignored single cycles
    sgl(6'h0D, adr(8'h10), 0, 1, 32'h0BADF00D, 0, rv, ak);
    chk("R5 unsupported modifier no acknowledge", 64'(ak), 64'd0);
    sgl(6'h09, {BASE ^ 24'h1, 8'h10}, 0, 1, 32'h0BADF00D, 0, rv, ak);
    chk("R6 base mismatch no acknowledge", 64'(ak), 64'd0);
    sgl(6'h09, adr(8'h10), 1, 1, 32'h0BADF00D, 0, rv, ak);
    chk("R7 narrow width no acknowledge", 64'(ak), 64'd0);
    sgl(6'h09, adr(8'h12), 0, 1, 32'h0BADF00D, 0, rv, ak);
    chk("R7 address bit 1 no acknowledge", 64'(ak), 64'd0);
    sgl(6'h09, adr(8'h10), 0, 0, 32'h0, 1, rv, ak);
    chk("R5/R6/R7 store unchanged", 64'(rv), 64'(ref_mem[4]));

    // block write of three beats
    bdat[0] = 64'h1111_2222_3333_4444;
    bdat[1] = 64'hAAAA_BBBB_CCCC_DDDD;
    bdat[2] = 64'h0123_4567_89AB_CDEF;
    blk(adr(8'h20), 1, 3, 1, ok);
    chk("R8 block write handshakes", 64'(ok), 64'd1);
    for (int i = 0; i < 3; i++) begin
      ref_mem[8 + 2*i] = bdat[i][31:0];
      ref_mem[9 + 2*i] = bdat[i][63:32];
    end
    for (int w = 8; w < 14; w++) begin
      sgl(6'h09, adr(8'(w * 4)), 0, 0, 32'h0, 1, rv, ak);
      chk("R8 block word landed", 64'(rv), 64'(ref_mem[w]));
    end

    // block write across the window top
    bdat[0] = 64'hF0F0_0001_F0F0_0002;
    bdat[1] = 64'hF8F8_0003_F8F8_0004;
    bdat[2] = 64'h0000_0005_0000_0006;
    blk(adr(8'hF0), 1, 3, 1, ok);
    chk("R9 wrapping block handshakes", 64'(ok), 64'd1);
    for (int i = 0; i < 3; i++) begin
      off = 8'(8'hF0 + 8 * i);
      ref_mem[off >> 2]       = bdat[i][31:0];
      ref_mem[(off >> 2) + 1] = bdat[i][63:32];
    end
    sgl(6'h09, adr(8'hF8), 0, 0, 32'h0, 1, rv, ak);
    chk("R9 second beat at 0xF8", 64'(rv), 64'(ref_mem[62]));
    sgl(6'h09, adr(8'h00), 0, 0, 32'h0, 1, rv, ak);
    chk("R9 wrapped low word at 0x00", 64'(rv), 64'(ref_mem[0]));
    sgl(6'h09, adr(8'h04), 0, 0, 32'h0, 1, rv, ak);
    chk("R9 wrapped high word at 0x04", 64'(rv), 64'(ref_mem[1]));

    // block read
    blk(adr(8'h20), 0, 3, 1, ok);
    chk("R10 block read handshakes", 64'(ok), 64'd1);
    for (int i = 0; i < 3; i++)
      chk("R10 block read word", bdat[i], {ref_mem[9 + 2*i], ref_mem[8 + 2*i]});

    // misaligned block start
    blk(adr(8'h24), 1, 1, 0, ok);
    chk("R12 misaligned block no acknowledge", 64'(ok), 64'd1);
    sgl(6'h09, adr(8'h24), 0, 0, 32'h0, 1, rv, ak);
    chk("R12 store unchanged", 64'(rv), 64'(ref_mem[9]));

    repeat (4) @(negedge clk);
    chk("R11 board-select count", 64'(bsel_cnt), 64'(accepted));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule